// File: doc/BRIEF.md
# Fractional UART baud generator

This block derives the two timing strobes a UART needs from the system clock: a sample strobe at sixteen times the bit rate and a bit strobe once per bit period. The divide ratio is not restricted to a multiple of sixteen. Software programs an integer sub-sample length together with a 4-bit fractional extension, and every bit period then lasts exactly 16*(div+1)+ext system clocks.

The extra clocks are spread out rather than added as a stall at the end of the bit. Within each bit period, the first `ext` of the sixteen sub-samples are one clock longer than the rest. This keeps the sampling points of the receiver close to their ideal positions. The fastest setting is div=0 and ext=0, where the sample strobe fires on every clock and the bit rate is the system clock divided by 16.

Configuration arrives through a write-only register port made of a write strobe, an address and a data word. Address 0 holds the low divisor word and address 1 holds the high divisor word. Writing either one restarts the bit period, so the new timing begins on a clean boundary.

Top module: `fractional_baud_gen`

## Requirements
- R1: The synchronous active-high reset clears div and ext to zero and clears both counters. After reset, `sample_tick` is high on every clock and `bit_tick` is high on every 16th clock, the first being the 16th clock after reset.
- R2: With div and ext fixed, consecutive `bit_tick` pulses are exactly 16*(div+1)+ext clocks apart.
- R3: Within a bit period, sub-samples 0 to ext-1 last div+2 clocks each and the remaining ones last div+1 clocks each. A sub-sample ends with one clock of `sample_tick`.
- R4: `bit_tick` is high for one clock, only in the clock where the 16th sample strobe of the bit period is high.
- R5: A write to address 0 loads div[7:0] from data bits 7:0 and ext from data bits 15:12. Data bits 11:8 have no effect.
- R6: A write to address 1 loads div[15:8] from data bits 7:0. Data bits 15:8 of that write have no effect.
- R7: A write to the low register leaves div[15:8] unchanged, and a write to the high register leaves div[7:0] and ext unchanged.
- R8: A write to address 0 or 1 restarts timing. The clock after the write edge is clock 1 of a new bit period using the new values, so the first `sample_tick` arrives in clock div+1 (div+2 if ext>0) and the first `bit_tick` arrives in clock 16*(div+1)+ext.
- R9: A write to any other address (2 or 3) changes neither the configuration nor the current timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 is the low divisor word, 1 is the high divisor word |
| wr_data | input | 16 | Write data |
| sample_tick | output | 1 | One-clock strobe at the end of each sub-sample (16 per bit) |
| bit_tick | output | 1 | One-clock strobe at the end of each bit period |

## Verification
The hardest situation to reach is a restart that lands mid-period, partway through a stretched sub-sample. It must discard the partial count rather than finish it, and a write to an unmapped address at that same moment must leave the count untouched. The stimulus writes the registers at arbitrary points inside a running bit period, including inside long sub-samples. A behavioural model tracks the position within the bit period from cumulative sub-sample lengths and compares both strobes on every clock. Separate measurements time whole bit periods, individual sub-sample lengths and the delay from a write to the first strobes.

// File: rtl/baud_pkg.sv
package baud_pkg;

    // Sixteen sub-samples per bit; the fractional extension indexes them.
    localparam int SUB_IDX_W = 4;
    localparam int SUBS_PER_BIT = 1 << SUB_IDX_W;

    // Which divisor word a write targets.
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_LOW  = 2'd1,
        SEL_HIGH = 2'd2
    } reg_sel_e;

    // The two strobes leaving the block.
    typedef struct packed {
        logic sample;
        logic bit_end;
    } tick_t;

    // A sub-sample is stretched by one clock when its index is below ext.
    function automatic logic sub_is_long(input logic [SUB_IDX_W-1:0] sub,
                                         input logic [SUB_IDX_W-1:0] ext);
        return sub < ext;
    endfunction

endpackage

// File: rtl/baud_cfg_regs.sv
module baud_cfg_regs
    import baud_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int DIV_LO_W = 8,
    parameter int DIV_HI_W = 8,
    parameter int ADDR_W   = 2,
    parameter int LO_ADDR  = 0,
    parameter int HI_ADDR  = 1,
    localparam int DIV_W   = DIV_LO_W + DIV_HI_W,
    localparam int EXT_LSB = DATA_W - SUB_IDX_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [DIV_W-1:0]     div,
    output logic [SUB_IDX_W-1:0] ext,
    output logic                 restart
);

    reg_sel_e sel;

    always_comb begin
        sel = SEL_NONE;
        if (wr_en) begin
            if (wr_addr == ADDR_W'(LO_ADDR))
                sel = SEL_LOW;
            else if (wr_addr == ADDR_W'(HI_ADDR))
                sel = SEL_HIGH;
        end
    end

    assign restart = (sel != SEL_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            div <= '0;
            ext <= '0;
        end else begin
            case (sel)
                SEL_LOW: begin
                    div[DIV_LO_W-1:0] <= wr_data[DIV_LO_W-1:0];
                    ext               <= wr_data[EXT_LSB +: SUB_IDX_W];
                end
                SEL_HIGH: begin
                    div[DIV_W-1:DIV_LO_W] <= wr_data[DIV_HI_W-1:0];
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/baud_sub_counter.sv
module baud_sub_counter #(
    parameter int DIV_W   = 16,
    localparam int CNT_W  = DIV_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    input  logic             extend,
    output logic             sample
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    // Final count of this sub-sample: div, or div+1 when stretched.
    assign last   = {1'b0, div} + {{DIV_W{1'b0}}, extend};
    assign sample = (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (sample)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/baud_bit_counter.sv
module baud_bit_counter
    import baud_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 restart,
    input  logic                 sample,
    input  logic [SUB_IDX_W-1:0] ext,
    output logic                 extend,
    output logic                 bit_end
);

    logic [SUB_IDX_W-1:0] sub;

    assign extend  = sub_is_long(sub, ext);
    assign bit_end = sample && (sub == SUB_IDX_W'(SUBS_PER_BIT - 1));

    always_ff @(posedge clk) begin
        if (rst || restart)
            sub <= '0;
        else if (sample)
            sub <= sub + 1'b1;
    end

endmodule

// File: rtl/fractional_baud_gen.sv
module fractional_baud_gen
    import baud_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int DIV_LO_W = 8,
    parameter int DIV_HI_W = 8,
    parameter int ADDR_W   = 2,
    parameter int LO_ADDR  = 0,
    parameter int HI_ADDR  = 1,
    localparam int DIV_W   = DIV_LO_W + DIV_HI_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              sample_tick,
    output logic              bit_tick
);

    logic [DIV_W-1:0]     cfg_div;
    logic [SUB_IDX_W-1:0] cfg_ext;
    logic                 restart;
    logic                 extend;
    tick_t                ticks;

    baud_cfg_regs #(
        .DATA_W   (DATA_W),
        .DIV_LO_W (DIV_LO_W),
        .DIV_HI_W (DIV_HI_W),
        .ADDR_W   (ADDR_W),
        .LO_ADDR  (LO_ADDR),
        .HI_ADDR  (HI_ADDR)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .div     (cfg_div),
        .ext     (cfg_ext),
        .restart (restart)
    );

    baud_sub_counter #(
        .DIV_W (DIV_W)
    ) u_sub (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .div     (cfg_div),
        .extend  (extend),
        .sample  (ticks.sample)
    );

    baud_bit_counter u_bit (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .sample  (ticks.sample),
        .ext     (cfg_ext),
        .extend  (extend),
        .bit_end (ticks.bit_end)
    );

    assign sample_tick = ticks.sample;
    assign bit_tick    = ticks.bit_end;

endmodule

// File: rtl/fractional_baud_gen_chk.sv
module fractional_baud_gen_chk #(
    parameter int DATA_W   = 16,
    parameter int DIV_LO_W = 8,
    parameter int DIV_W    = 16,
    parameter int EXT_W    = 4,
    parameter int ADDR_W   = 2,
    parameter int LO_ADDR  = 0,
    parameter int HI_ADDR  = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              sample_tick,
    input logic              bit_tick,
    input logic [DIV_W-1:0]  cfg_div,
    input logic [EXT_W-1:0]  cfg_ext
);

    logic lo_wr, hi_wr, odd_wr;
    assign lo_wr  = wr_en && (wr_addr == ADDR_W'(LO_ADDR));
    assign hi_wr  = wr_en && (wr_addr == ADDR_W'(HI_ADDR));
    assign odd_wr = wr_en && !lo_wr && !hi_wr;

    // R4
    bit_needs_sample_chk: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> sample_tick);

    // R4
    bit_single_clock_chk: assert property (@(posedge clk) disable iff (rst)
        bit_tick |=> !bit_tick);

    // R3
    long_first_sub_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_tick && cfg_div != '0 && !lo_wr && !hi_wr) |=> !sample_tick);

    // R8
    restart_no_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (lo_wr || hi_wr) |=> !bit_tick);

    // R5
    low_write_load_chk: assert property (@(posedge clk) disable iff (rst)
        lo_wr |=> (cfg_div[DIV_LO_W-1:0] == $past(wr_data[DIV_LO_W-1:0]))
               && (cfg_ext == $past(wr_data[DATA_W-1 -: EXT_W])));

    // R7
    low_keeps_high_chk: assert property (@(posedge clk) disable iff (rst)
        lo_wr |=> $stable(cfg_div[DIV_W-1:DIV_LO_W]));

    // R9
    odd_addr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        odd_wr |=> ($stable(cfg_div) && $stable(cfg_ext)));

endmodule

bind fractional_baud_gen fractional_baud_gen_chk #(
    .DATA_W   (DATA_W),
    .DIV_LO_W (DIV_LO_W),
    .DIV_W    (DIV_W),
    .EXT_W    (baud_pkg::SUB_IDX_W),
    .ADDR_W   (ADDR_W),
    .LO_ADDR  (LO_ADDR),
    .HI_ADDR  (HI_ADDR)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .sample_tick (sample_tick),
    .bit_tick    (bit_tick),
    .cfg_div     (cfg_div),
    .cfg_ext     (cfg_ext)
);

// File: tb/fractional_baud_gen_test.sv
module fractional_baud_gen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        sample_tick, bit_tick;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    // Reference state.
    int  m_div = 0, m_ext = 0, m_pos = 0;
    bit  m_valid = 0;

    always #2 clk = ~clk;

    fractional_baud_gen uut (
        .clk (clk), .rst (rst), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data), .sample_tick (sample_tick), .bit_tick (bit_tick)
    );

    function automatic int period(input int d, input int e);
        return 16 * (d + 1) + e;
    endfunction

    function automatic bit exp_sample(input int p, input int d, input int e);
        int acc = 0;
        for (int k = 0; k < 16; k++) begin
            acc += d + 1 + ((k < e) ? 1 : 0);
            if (p == acc - 1) return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Model advances on every rising edge using the inputs held there.
    always @(posedge clk) begin
        if (rst) begin
            m_div = 0; m_ext = 0; m_pos = 0; m_valid = 1;
        end else if (wr_en && wr_addr == 2'd0) begin
            m_div = (m_div & 32'hFF00) | int'(wr_data[7:0]);
            m_ext = int'(wr_data[15:12]);
            m_pos = 0;
        end else if (wr_en && wr_addr == 2'd1) begin
            m_div = (m_div & 32'h00FF) | (int'(wr_data[7:0]) << 8);
            m_pos = 0;
        end else begin
            m_pos = (m_pos + 1) % period(m_div, m_ext);
        end
    end

    // Per-clock comparison away from the edge.
    always @(negedge clk) begin
        cycles++;
        if (m_valid && !done) begin
            check("R3 sample_tick vs model", sample_tick,
                  exp_sample(m_pos, m_div, m_ext));
            check("R4 bit_tick vs model", bit_tick,
                  m_pos == period(m_div, m_ext) - 1);
        end
        if (cycles > 150000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", cycles, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic write_reg(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; wr_addr = '0;
    endtask

    task automatic measure_period(input string req, input int exp);
        int n = 0;
        while (!bit_tick) @(negedge clk);
        do begin
            @(negedge clk);
            n++;
        end while (!bit_tick);
        check(req, n, exp);
    endtask

    // Called at the negedge right after a write edge (clock 1).
    task automatic measure_restart(input int d, input int e);
        int n = 1, first_s = 0;
        while (!bit_tick) begin
            if (sample_tick && first_s == 0) first_s = n;
            @(negedge clk);
            n++;
        end
        if (first_s == 0) first_s = n;
        check("R8 first sample after write", first_s, d + 1 + ((e > 0) ? 1 : 0));
        check("R8 first bit after write", n, period(d, e));
    endtask

    task automatic measure_subs(input int d, input int e);
        int n;
        while (!bit_tick) @(negedge clk);
        for (int k = 0; k < 16; k++) begin
            n = 0;
            do begin
                @(negedge clk);
                n++;
            end while (!sample_tick);
            check($sformatf("R3 sub-sample %0d length", k), n,
                  d + 1 + ((k < e) ? 1 : 0));
        end
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        // R1: first clock after reset has a sample strobe, bit on 16th
        @(negedge clk);
        check("R1 sample after reset", sample_tick, 1);
        check("R1 no bit on clock 1", bit_tick, 0);
        measure_period("R1 reset bit period", 16);

        // R5: ext=3, div=5, bits 11:8 set and ignored
        write_reg(2'd0, 16'h3F05);
        measure_restart(5, 3);
        measure_period("R2 period div5 ext3", period(5, 3));
        measure_subs(5, 3);

        // R5/R2: ext=15 at fastest integer rate
        write_reg(2'd0, 16'hF000);
        measure_restart(0, 15);
        measure_period("R2 period div0 ext15", period(0, 15));
        measure_subs(0, 15);

        // R6/R7: high word, upper data bits ignored, low half kept
        write_reg(2'd0, 16'h7023);
        write_reg(2'd1, 16'hAB01);
        measure_restart(16'h0123, 7);
        measure_period("R6 R7 period div 0x123 ext7", period(16'h0123, 7));

        // R9: unmapped writes mid-period do not restart or reconfigure
        write_reg(2'd0, 16'h2002);
        write_reg(2'd1, 16'h0000);
        repeat (7) @(negedge clk);
        write_reg(2'd2, 16'hFFFF);
        repeat (3) @(negedge clk);
        write_reg(2'd3, 16'h0000);
        measure_period("R9 period after odd writes", period(2, 2));

        // R8: restart in the middle of a stretched sub-sample
        repeat (5) @(negedge clk);
        write_reg(2'd0, 16'h1004);
        measure_restart(4, 1);
        measure_period("R2 period div4 ext1", period(4, 1));

        // R1: reset mid-run returns to the fastest rate
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 sample after second reset", sample_tick, 1);
        measure_period("R1 period after second reset", 16);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule